// File: doc/BRIEF.md
# Clocked Controller for Asynchronous Static RAM

This block sits between a synchronous host and an external asynchronous static RAM with a 16-bit word and two byte lanes. The host offers one request at a time over a valid/ready handshake: a direction flag, a word address, write data and a per-lane enable mask. The controller turns each request into a sequence of registered, active-low strobes on the memory side: chip select, write strobe, output enable and one select per byte lane. It also drives a data-out bus with its own drive enable and captures the memory's data-in bus.

Every memory timing figure is a parameter in picoseconds. The controller converts each one to clock cycles by ceiling division by the clock period, with a minimum of one cycle. From these it derives the length of the read window and of the write strobe. Writes are ended by the write strobe rising. The controller never turns its drivers on until the memory's outputs have had the output-to-float time to release the bus. Between transactions the chip select is parked high.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and straight after a synchronous reset: `req_ready`=1, `sram_ce_n`=`sram_we_n`=`sram_oe_n`=1, `sram_bs_n`=all ones, `sram_dq_oe`=0 and `rd_valid`=0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the edge that ends the transaction. Chip select is high for at least one cycle between two transactions. A request held while `req_ready` is 0 waits and is taken later.
- R3: A read (`req_we`=0) holds `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for READ_CYC = max(cyc(T_AA), cyc(T_OE)) cycles. Here cyc(t) = max(1, ceil(t/CLK_PS)).
- R4: A write (`req_we`=1) holds `sram_ce_n`=0, `sram_we_n`=0 and `sram_oe_n`=1 for WE_LOW_CYC = max(cyc(T_WP), cyc(T_CW), cyc(T_BW), cyc(T_AA), cyc(T_HZ)+cyc(T_DW)) cycles. Both strobes then rise on the same edge.
- R5: During a write, `sram_dq_oe` stays 0 for the first cyc(T_HZ) cycles of the strobe. It is then 1 with `sram_dq_out` equal to the request's write data until the edge where `sram_we_n` rises, where it returns to 0.
- R6: `sram_bs_n[0]` (data bits 7:0) is low during a transaction if and only if `req_be[0]` was 1, and `sram_bs_n[1]` (bits 15:8) if and only if `req_be[1]` was 1. This holds for reads and writes. Lanes with a clear enable are not written, and they read back as zero in `rd_data`.
- R7: `sram_addr` equals the request address and stays stable for the whole time chip select is low.
- R8: `sram_oe_n` and `sram_we_n` are never low together, and `sram_dq_oe` is never 1 while `sram_oe_n` is 0.
- R9: `rd_valid` is a single-cycle pulse on the edge that ends a read. `rd_data` then holds the memory data sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Lane enable mask, bit 0 = bits 7:0 |
| rd_data | output | DATA_W | Read result, disabled lanes zero |
| rd_valid | output | 1 | Read result strobe |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_bs_n | output | DATA_W/8 | Per-lane select, active low |
| sram_dq_out | output | DATA_W | Data driven toward memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | DATA_W | Data returned by memory |

## Verification
The bench is built with timing figures that make the read window three cycles, the write strobe four and the float delay two. An off-by-one in any derived count therefore moves a strobe edge that the per-clock reference model sees. It places a write right behind a read. A controller that drove the bus too early would overlap its drivers with the memory's outputs, and the bench model flags that as contention. Single-lane writes and reads would expose swapped or ignored lane selects as corrupted neighbour bytes or non-zero masked lanes. A request held high while the controller is busy would expose a handshake that double-accepts or drops it. The address extremes 0 and all ones would expose truncated address paths.

// File: rtl/sram_async_pkg.sv
package sram_async_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_t;

  // picoseconds to whole clock cycles, never below one
  function automatic int unsigned to_cycles(input int unsigned t_ps,
                                            input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int unsigned max_of(input int unsigned a,
                                         input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic [LANES-1:0]  be_req,
  input  logic [LANES-1:0]  be_act,
  input  logic [DATA_W-1:0] raw_in,
  output logic [LANES-1:0]  sel_n,
  output logic [DATA_W-1:0] masked_in
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_n[g]             = ~be_req[g];
    assign masked_in[g*8 +: 8]  = be_act[g] ? raw_in[g*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_async_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int LANES      = DATA_W / 8,
  parameter int CNT_W      = 4,
  parameter int READ_CYC   = 1,
  parameter int WE_LOW_CYC = 2,
  parameter int HZ_CYC     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  sel_n_req,
  input  logic [DATA_W-1:0] rd_masked,
  input  logic [CNT_W-1:0]  count,
  output logic              timer_clear,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [LANES-1:0]  sram_bs_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe
);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WE_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_ON  = CNT_W'(HZ_CYC - 1);

  seq_state_t state;

  assign timer_clear = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      req_ready   <= 1'b1;
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      sram_addr   <= '0;
      sram_ce_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_bs_n   <= '1;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            req_ready   <= 1'b0;
            sram_ce_n   <= 1'b0;
            sram_addr   <= req_addr;
            sram_bs_n   <= sel_n_req;
            sram_dq_out <= req_wdata;
            if (req_we) begin
              state     <= ST_WRITE;
              sram_we_n <= 1'b0;
            end else begin
              state     <= ST_READ;
              sram_oe_n <= 1'b0;
            end
          end
        end
        ST_READ: begin
          if (count == RD_LAST) begin
            rd_data   <= rd_masked;
            rd_valid  <= 1'b1;
            sram_ce_n <= 1'b1;
            sram_oe_n <= 1'b1;
            sram_bs_n <= '1;
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_WRITE: begin
          if (count == WR_LAST) begin
            sram_ce_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
            sram_bs_n  <= '1;
            req_ready  <= 1'b1;
            state      <= ST_IDLE;
          end else if (count == DRV_ON) begin
            sram_dq_oe <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_async_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CLK_PS  = 20000,
  parameter int T_AA_PS = 10000,
  parameter int T_OE_PS = 5000,
  parameter int T_WP_PS = 7000,
  parameter int T_CW_PS = 8000,
  parameter int T_BW_PS = 7000,
  parameter int T_DW_PS = 5000,
  parameter int T_HZ_PS = 5000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic [ADDR_W-1:0]     sram_addr,
  output logic                  sram_ce_n,
  output logic                  sram_we_n,
  output logic                  sram_oe_n,
  output logic [DATA_W/8-1:0]   sram_bs_n,
  output logic [DATA_W-1:0]     sram_dq_out,
  output logic                  sram_dq_oe,
  input  logic [DATA_W-1:0]     sram_dq_in
);

  localparam int LANES      = DATA_W / 8;
  localparam int AA_CYC     = to_cycles(T_AA_PS, CLK_PS);
  localparam int OE_CYC     = to_cycles(T_OE_PS, CLK_PS);
  localparam int WP_CYC     = to_cycles(T_WP_PS, CLK_PS);
  localparam int CW_CYC     = to_cycles(T_CW_PS, CLK_PS);
  localparam int BW_CYC     = to_cycles(T_BW_PS, CLK_PS);
  localparam int DW_CYC     = to_cycles(T_DW_PS, CLK_PS);
  localparam int HZ_CYC     = to_cycles(T_HZ_PS, CLK_PS);
  localparam int READ_CYC   = max_of(AA_CYC, OE_CYC);
  localparam int WE_LOW_CYC = max_of(max_of(max_of(WP_CYC, CW_CYC),
                                            max_of(BW_CYC, AA_CYC)),
                                     HZ_CYC + DW_CYC);
  localparam int CNT_W      = $clog2(max_of(READ_CYC, WE_LOW_CYC) + 1);

  logic [LANES-1:0]  sel_n_req;
  logic [DATA_W-1:0] rd_masked;
  logic [CNT_W-1:0]  count;
  logic              timer_clear;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (timer_clear),
    .count (count)
  );

  sram_lane_ctrl #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
    .be_req    (req_be),
    .be_act    (~sram_bs_n),
    .raw_in    (sram_dq_in),
    .sel_n     (sel_n_req),
    .masked_in (rd_masked)
  );

  sram_seq_fsm #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LANES      (LANES),
    .CNT_W      (CNT_W),
    .READ_CYC   (READ_CYC),
    .WE_LOW_CYC (WE_LOW_CYC),
    .HZ_CYC     (HZ_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_we      (req_we),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .sel_n_req   (sel_n_req),
    .rd_masked   (rd_masked),
    .count       (count),
    .timer_clear (timer_clear),
    .req_ready   (req_ready),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_bs_n   (sram_bs_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W     = 16,
  parameter int READ_CYC   = 1,
  parameter int WE_LOW_CYC = 2,
  parameter int HZ_CYC     = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe
);

  int we_run;
  int oe_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_run <= 0;
      oe_run <= 0;
    end else begin
      we_run <= sram_we_n ? 0 : we_run + 1;
      oe_run <= sram_oe_n ? 0 : oe_run + 1;
    end
  end

  AST_READY_MEANS_STANDBY: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> sram_ce_n); // R2

  AST_READ_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_oe_n) |-> (oe_run == READ_CYC)); // R3

  AST_WRITE_STROBE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (we_run == WE_LOW_CYC && sram_ce_n)); // R4

  AST_DRIVE_AFTER_FLOAT: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> (we_run == HZ_CYC)); // R5

  AST_DRIVE_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (!sram_we_n && !sram_ce_n)); // R5

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R7

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> (sram_we_n && !sram_dq_oe)); // R8

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R9

  AST_RDVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(!sram_oe_n) && sram_oe_n)); // R9

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .READ_CYC   (READ_CYC),
  .WE_LOW_CYC (WE_LOW_CYC),
  .HZ_CYC     (HZ_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

  localparam int CLK_PS = 20000;
  localparam int AA_PS  = 45000;
  localparam int HZ_PS  = 25000;
  localparam int DW_PS  = 30000;

  function automatic int cyc(input int t);
    int n;
    n = (t + CLK_PS - 1) / CLK_PS;
    return (n < 1) ? 1 : n;
  endfunction

  // expected counts from R3/R4/R5 with the bench's timing figures
  localparam int RL = 3;   // max(cyc(45000)=3, cyc(5000)=1)
  localparam int HZ = 2;   // cyc(25000)
  localparam int WL = 4;   // max(1,1,1,3, 2+2)

  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0;
  logic        req_ready;
  logic        req_we = 0;
  logic [15:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [1:0]  req_be = 0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [15:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n;
  logic [1:0]  sram_bs_n;
  logic [15:0] sram_dq_out;
  logic        sram_dq_oe;
  logic [15:0] sram_dq_in = 16'hBEEF;

  always #10 clk = ~clk;

  sram_async_ctrl #(
    .CLK_PS (CLK_PS), .T_AA_PS(AA_PS), .T_HZ_PS(HZ_PS), .T_DW_PS(DW_PS)
  ) i_sram_async_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rd_data(rd_data), .rd_valid(rd_valid),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_bs_n(sram_bs_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // ---------------- reference model (per clock) ----------------
  logic [15:0] shadow [int];
  bit          m_busy, m_wr, m_ready, m_rdv;
  int          m_pos;
  logic [15:0] m_addr, m_wdata, m_rdd, m_rd_exp;
  logic [1:0]  m_be;

  function automatic logic [15:0] sh_get(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_wr <= 0; m_ready <= 1; m_rdv <= 0; m_pos <= 0;
      m_addr <= 0; m_be <= 0; m_wdata <= 0; m_rdd <= 0;
    end else begin
      m_rdv <= 0;
      if (m_busy) begin
        if (m_pos + 1 == (m_wr ? WL : RL)) begin
          m_busy <= 0; m_ready <= 1;
          if (!m_wr) begin m_rdv <= 1; m_rdd <= m_rd_exp; end
        end else m_pos <= m_pos + 1;
      end else if (m_ready && req_valid) begin
        logic [15:0] cur;
        m_busy <= 1; m_pos <= 0; m_ready <= 0; m_wr <= req_we;
        m_addr <= req_addr; m_be <= req_be; m_wdata <= req_wdata;
        cur = sh_get(int'(req_addr));
        if (req_we) begin
          if (req_be[0]) cur[7:0]  = req_wdata[7:0];
          if (req_be[1]) cur[15:8] = req_wdata[15:8];
          shadow[int'(req_addr)] = cur;
        end else begin
          m_rd_exp <= {req_be[1] ? cur[15:8] : 8'h00, req_be[0] ? cur[7:0] : 8'h00};
        end
      end
    end
  end

  // ---------------- memory model and per-clock compare ----------------
  logic [15:0] mem [int];
  bit          pend = 0;
  logic [15:0] p_addr, p_data;
  logic [1:0]  p_bs_n;

  always @(negedge clk) begin
    if (!rst) begin
      // R1..R9 cycle compare against the model
      chk(req_ready == m_ready, "R2", "req_ready", req_ready, m_ready);
      chk(sram_ce_n == !m_busy, "R2", "ce_n", sram_ce_n, !m_busy);
      chk(sram_we_n == !(m_busy && m_wr), "R4", "we_n", sram_we_n, !(m_busy && m_wr));
      chk(sram_oe_n == !(m_busy && !m_wr), "R3", "oe_n", sram_oe_n, !(m_busy && !m_wr));
      chk(sram_dq_oe == (m_busy && m_wr && m_pos >= HZ), "R5", "dq_oe",
          sram_dq_oe, (m_busy && m_wr && m_pos >= HZ));
      chk(sram_bs_n == (m_busy ? ~m_be : 2'b11), "R6", "bs_n",
          sram_bs_n, (m_busy ? ~m_be : 2'b11));
      if (m_busy) chk(sram_addr == m_addr, "R7", "addr", sram_addr, m_addr);
      if (sram_dq_oe) chk(sram_dq_out == m_wdata, "R5", "dq_out", sram_dq_out, m_wdata);
      chk(rd_valid == m_rdv, "R9", "rd_valid", rd_valid, m_rdv);
      if (m_rdv) chk(rd_data == m_rdd, "R9", "rd_data", rd_data, m_rdd);
      if (sram_dq_oe && !sram_oe_n) chk(0, "R8", "bus contention", 1, 0);
    end
    // write lands when the strobe rises
    if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
      pend = 1; p_addr = sram_addr; p_data = sram_dq_out; p_bs_n = sram_bs_n;
    end else if (sram_we_n && pend) begin
      logic [15:0] w;
      w = mem.exists(int'(p_addr)) ? mem[int'(p_addr)] : 16'h0000;
      if (!p_bs_n[0]) w[7:0]  = p_data[7:0];
      if (!p_bs_n[1]) w[15:8] = p_data[15:8];
      mem[int'(p_addr)] = w;
      pend = 0;
    end
    if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
      logic [15:0] r;
      r = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 16'h0000;
      sram_dq_in = {sram_bs_n[1] ? 8'hA5 : r[15:8], sram_bs_n[0] ? 8'hA5 : r[7:0]};
    end else begin
      sram_dq_in = 16'hBEEF;
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit we, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    bit rdy;
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    do begin
      rdy = req_ready;
      @(negedge clk);
    end while (!rdy);
    req_valid = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    issue(1, a, d, be);
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] be, input logic [15:0] exp,
                    input string req);
    issue(0, a, 16'h0, be);
    while (!rd_valid) @(negedge clk);
    chk(rd_data == exp, req, "directed read", rd_data, exp);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      chk(0, "R2", "watchdog expired", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(req_ready == 1, "R1", "ready in reset", req_ready, 1);
    chk({sram_ce_n, sram_we_n, sram_oe_n} == 3'b111, "R1", "strobes in reset",
        {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
    chk(sram_bs_n == 2'b11, "R1", "bs_n in reset", sram_bs_n, 2'b11);
    chk(sram_dq_oe == 0 && rd_valid == 0, "R1", "oe/valid in reset",
        {sram_dq_oe, rd_valid}, 0);
    rst = 0;
    @(negedge clk);

    wr(16'h0000, 16'h1234, 2'b11);
    rd(16'h0000, 2'b11, 16'h1234, "R3");
    wr(16'hFFFF, 16'hABCD, 2'b11);          // R7 top address
    rd(16'hFFFF, 2'b11, 16'hABCD, "R7");
    wr(16'h0010, 16'h5566, 2'b11);
    wr(16'h0010, 16'h99EE, 2'b01);          // R6 lower lane only
    rd(16'h0010, 2'b11, 16'h55EE, "R6");
    wr(16'h0010, 16'h7700, 2'b10);          // R6 upper lane only
    rd(16'h0010, 2'b01, 16'h00EE, "R6");
    rd(16'h0010, 2'b10, 16'h7700, "R6");
    wr(16'h0010, 16'hFFFF, 2'b00);          // R6 no lane: no change
    rd(16'h0010, 2'b11, 16'h77EE, "R6");

    // back-to-back, request held while busy (R2), write behind read (R8)
    lcg = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      issue(lcg[0], {8'h00, lcg[15:8]} & 16'h003F, lcg[31:16], lcg[3:2]);
    end
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule